// File: doc/BRIEF.md
# Dual-path add/subtract execution unit

This unit executes one kind of SIMD-extension instruction. A single instruction word selects two 32-bit source registers and two destination registers from a bank of sixteen entries. It produces two independent results from the same operand pair. Each result is either the sum or the difference of the two sources, and a two-bit pattern field picks the operation for each one. Every result path also produces a carry indication, which goes into its own high bit of a 32-bit control register. All other control bits keep their values.

The unit holds the register bank, whose entry 0 always reads as zero, and the control register. It accepts at most one instruction per clock when `insn_valid` is high. Two combinational peek ports read bank entries for observation. A load port lets a test environment place operands in the bank.

Top module: `dpas_unit`

## Requirements
- R1: An instruction is executed only when `insn_valid` is high, bits [31:26] equal 0x1C and bits [5:0] equal 0x18. Any other word, or a low strobe, changes no register and no control bit.
- R2: The first destination index is bits [9:6]. The first source index is bits [13:10]. The second source index is bits [17:14]. The second destination index is bits [21:18]. The pattern is bits [25:24] and the padding is bits [23:22].
- R3: A recognised word with nonzero padding changes no register and no control bit.
- R4: A recognised word whose two destination indices are both 0 changes no register and no control bit.
- R5: The first path computes first source minus second source when pattern bit 1 (word bit 25) is 1, and the 32-bit wrapped sum otherwise. The second path does the same, selected by pattern bit 0 (word bit 24).
- R6: For a subtraction, the path's carry is 1 exactly when the first source is strictly greater than the second source as unsigned numbers. Equal operands give 0.
- R7: For an addition, the path's carry is 1 exactly when the first source is strictly greater than the wrapped sum as unsigned numbers.
- R8: The first path's carry replaces control bit 31 and the second path's carry replaces control bit 30. Bits 29 to 0 are never changed by an instruction.
- R9: A path whose destination index is 0 writes neither a register nor its control bit, and the other path still completes.
- R10: Both sources are read before either destination is written, so a destination equal to a source does not change the other path's result.
- R11: Entry 0 always reads as zero, and writes to it from either path or from the load port are dropped.
- R12: Synchronous active-high reset clears every bank entry and the control register. Results and carries become visible on the outputs after the clock edge that samples the instruction.
- R13: When both destination indices are equal and nonzero, the entry keeps the second path's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction strobe |
| insn_word | input | 32 | Instruction word |
| ld_en | input | 1 | Load-port write enable |
| ld_idx | input | 4 | Load-port entry index |
| ld_data | input | 32 | Load-port write data |
| peek_idx_a | input | 4 | Peek port A entry index |
| peek_data_a | output | 32 | Peek port A data (combinational) |
| peek_idx_b | input | 4 | Peek port B entry index |
| peek_data_b | output | 32 | Peek port B data (combinational) |
| ctl_reg | output | 32 | Control register |

## Verification
Every result, destination write and carry bit is due exactly one clock edge after the edge that samples a valid instruction. The peek ports are combinational, so a bank entry can be read as soon as that edge has passed. The bench drives the instruction and operand loads on falling edges and holds each one for a single rising edge. It then reads the peek ports and the control register on the following falling edge, half a period after the update. For the cases where the instruction must be ignored, the same post-edge sample must still show the values the bank and control register held before the instruction.

// File: rtl/dpas_pkg.sv
package dpas_pkg;

    localparam int IDXW  = 4;
    localparam int WORDW = 32;

    typedef struct packed {
        logic [5:0]      major;
        logic [1:0]      pat;
        logic [1:0]      pad;
        logic [IDXW-1:0] dst2;
        logic [IDXW-1:0] src2;
        logic [IDXW-1:0] src1;
        logic [IDXW-1:0] dst1;
        logic [5:0]      minor;
    } insn_t;

    typedef struct packed {
        logic            w1;
        logic            w2;
        logic            sub1;
        logic            sub2;
        logic [IDXW-1:0] s1;
        logic [IDXW-1:0] s2;
        logic [IDXW-1:0] d1;
        logic [IDXW-1:0] d2;
    } dec_t;

endpackage

// File: rtl/dpas_decode.sv
module dpas_decode
    import dpas_pkg::*;
#(
    parameter logic [5:0] MAJOR = 6'h1C,
    parameter logic [5:0] MINOR = 6'h18
) (
    input  logic             valid,
    input  logic [WORDW-1:0] word,
    output dec_t             dec
);
    insn_t f;
    logic  hit;

    always_comb begin
        f   = insn_t'(word);
        hit = valid && (f.major == MAJOR) && (f.minor == MINOR) && (f.pad == 2'b00);
        dec.w1   = hit && (f.dst1 != '0);
        dec.w2   = hit && (f.dst2 != '0);
        dec.sub1 = f.pat[1];
        dec.sub2 = f.pat[0];
        dec.s1   = f.src1;
        dec.s2   = f.src2;
        dec.d1   = f.dst1;
        dec.d2   = f.dst2;
    end
endmodule

// File: rtl/dpas_path.sv
module dpas_path #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy
);
    always_comb begin
        if (sub) begin
            res = a - b;
            cy  = (a > b);
        end else begin
            res = a + b;
            cy  = (a > res);
        end
    end
endmodule

// File: rtl/dpas_regbank.sv
module dpas_regbank #(
    parameter int W = 32,
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rs1,
    input  logic [IW-1:0] rs2,
    output logic [W-1:0]  op1,
    output logic [W-1:0]  op2,
    input  logic [IW-1:0] pa_idx,
    output logic [W-1:0]  pa_data,
    input  logic [IW-1:0] pb_idx,
    output logic [W-1:0]  pb_data,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data
);
    typedef struct packed {
        logic [N-1:1][W-1:0] r;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [W-1:0] rd(input bank_t bk, input logic [IW-1:0] idx);
        logic [W-1:0] v;
        v = '0;
        for (int i = 1; i < N; i++) begin
            if (idx == i[IW-1:0]) v = bk.r[i];
        end
        return v;
    endfunction

    always_comb begin
        op1     = rd(bank_q, rs1);
        op2     = rd(bank_q, rs2);
        pa_data = rd(bank_q, pa_idx);
        pb_data = rd(bank_q, pb_idx);
        bank_d  = bank_q;
        for (int i = 1; i < N; i++) begin
            if (ld_en && ld_idx == i[IW-1:0]) bank_d.r[i] = ld_data;
            if (wa_en && wa_idx == i[IW-1:0]) bank_d.r[i] = wa_data;
            if (wb_en && wb_idx == i[IW-1:0]) bank_d.r[i] = wb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end
endmodule

// File: rtl/dpas_unit.sv
module dpas_unit
    import dpas_pkg::*;
#(
    parameter int W = 32,
    parameter int N = 16,
    parameter logic [5:0] MAJOR = 6'h1C,
    parameter logic [5:0] MINOR = 6'h18,
    localparam int IW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid,
    input  logic [WORDW-1:0] insn_word,
    input  logic             ld_en,
    input  logic [IW-1:0]    ld_idx,
    input  logic [W-1:0]     ld_data,
    input  logic [IW-1:0]    peek_idx_a,
    output logic [W-1:0]     peek_data_a,
    input  logic [IW-1:0]    peek_idx_b,
    output logic [W-1:0]     peek_data_b,
    output logic [W-1:0]     ctl_reg
);
    typedef struct packed {
        logic [W-1:0] ctl;
    } state_t;

    dec_t         dec;
    state_t       st_d, st_q;
    logic [W-1:0] op1, op2;
    logic [1:0]   sub_sel;
    logic [W-1:0] res [2];
    logic [1:0]   cy;
    logic         w1_s, w2_s, sub1_s;

    dpas_decode #(.MAJOR(MAJOR), .MINOR(MINOR)) u_dec (
        .valid (insn_valid),
        .word  (insn_word),
        .dec   (dec)
    );

    dpas_regbank #(.W(W), .N(N)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .rs1     (dec.s1),
        .rs2     (dec.s2),
        .op1     (op1),
        .op2     (op2),
        .pa_idx  (peek_idx_a),
        .pa_data (peek_data_a),
        .pb_idx  (peek_idx_b),
        .pb_data (peek_data_b),
        .wa_en   (dec.w1),
        .wa_idx  (dec.d1),
        .wa_data (res[0]),
        .wb_en   (dec.w2),
        .wb_idx  (dec.d2),
        .wb_data (res[1]),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data)
    );

    assign sub_sel = {dec.sub2, dec.sub1};

    for (genvar g = 0; g < 2; g++) begin : g_path
        dpas_path #(.W(W)) u_path (
            .a   (op1),
            .b   (op2),
            .sub (sub_sel[g]),
            .res (res[g]),
            .cy  (cy[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (dec.w1) st_d.ctl[W-1] = cy[0];
        if (dec.w2) st_d.ctl[W-2] = cy[1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ctl_reg = st_q.ctl;
    assign w1_s    = dec.w1;
    assign w2_s    = dec.w2;
    assign sub1_s  = dec.sub1;
endmodule

// File: rtl/dpas_unit_chk.sv
module dpas_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         valid,
    input logic [1:0]   pad,
    input logic [3:0]   dst1,
    input logic [3:0]   dst2,
    input logic [W-1:0] ctl,
    input logic         w1,
    input logic         w2,
    input logic         sub1,
    input logic [W-1:0] op1,
    input logic [W-1:0] op2
);
    // R12: reset clears the control register
    a_r12_reset_clears: assert property (@(posedge clk) rst |=> (ctl == '0));

    // R3: nonzero padding leaves the control register alone
    a_r3_pad_ignored: assert property (@(posedge clk) disable iff (rst)
        (valid && pad != 2'b00) |=> $stable(ctl));

    // R4: both destinations zero leaves the control register alone
    a_r4_no_dest: assert property (@(posedge clk) disable iff (rst)
        (valid && dst1 == 4'd0 && dst2 == 4'd0) |=> $stable(ctl));

    // R8: low control bits never move
    a_r8_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
        valid |=> (ctl[W-3:0] == $past(ctl[W-3:0])));

    // R6: equal operands under subtraction give no carry
    a_r6_equal_sub_no_carry: assert property (@(posedge clk) disable iff (rst)
        (w1 && sub1 && op1 == op2) |=> !ctl[W-1]);

    // R9: a path that does not write keeps its control bit
    a_r9_skip_keeps_bit31: assert property (@(posedge clk) disable iff (rst)
        !w1 |=> $stable(ctl[W-1]));
    a_r9_skip_keeps_bit30: assert property (@(posedge clk) disable iff (rst)
        !w2 |=> $stable(ctl[W-2]));
endmodule

bind dpas_unit dpas_unit_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .valid (insn_valid),
    .pad   (insn_word[23:22]),
    .dst1  (insn_word[9:6]),
    .dst2  (insn_word[21:18]),
    .ctl   (ctl_reg),
    .w1    (w1_s),
    .w2    (w2_s),
    .sub1  (sub1_s),
    .op1   (op1),
    .op2   (op2)
);

// File: tb/dpas_unit_tb.sv
module dpas_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  peek_idx_a = '0;
    logic [31:0] peek_data_a;
    logic [3:0]  peek_idx_b = '0;
    logic [31:0] peek_data_b;
    logic [31:0] ctl_reg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dpas_unit u_dut (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_idx_a(peek_idx_a), .peek_data_a(peek_data_a),
        .peek_idx_b(peek_idx_b), .peek_data_b(peek_data_b),
        .ctl_reg(ctl_reg)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  pat;
        logic [31:0] r1;
        logic [31:0] r2;
        logic        c1;
        logic        c2;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{32'd5,        32'd3,        2'd0, 32'd8,        32'd8,        1'b0, 1'b0},
        '{32'd5,        32'd3,        2'd3, 32'd2,        32'd2,        1'b1, 1'b1},
        '{32'hFFFFFFFF, 32'd2,        2'd2, 32'hFFFFFFFD, 32'd1,        1'b1, 1'b1},
        '{32'd3,        32'd3,        2'd1, 32'd6,        32'd0,        1'b0, 1'b0},
        '{32'd2,        32'd5,        2'd3, 32'hFFFFFFFD, 32'hFFFFFFFD, 1'b0, 1'b0},
        '{32'h80000000, 32'h80000000, 2'd0, 32'd0,        32'd0,        1'b1, 1'b1},
        '{32'd0,        32'd7,        2'd2, 32'hFFFFFFF9, 32'd7,        1'b0, 1'b0}
    };

    function automatic logic [31:0] mk(input logic [1:0] pat, input logic [1:0] pad,
                                       input logic [3:0] d2, input logic [3:0] s2,
                                       input logic [3:0] s1, input logic [3:0] d1);
        return {6'h1C, pat, pad, d2, s2, s1, d1, 6'h18};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        insn_valid = 1'b1; insn_word = w;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [31:0] val);
        peek_idx_a = idx;
        #1 val = peek_data_a;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        check("R12 ctl after reset", ctl_reg, 32'h0);
        peek(4'd5, v);
        check("R12 entry after reset", v, 32'h0);
        peek_idx_b = 4'd9;
        #1 check("R12 port b after reset", peek_data_b, 32'h0);

        // Vector table: R2 R5 R6 R7 R8
        for (int i = 0; i < 7; i++) begin
            load(4'd1, VEC[i].a);
            load(4'd2, VEC[i].b);
            issue(mk(VEC[i].pat, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3));
            peek(4'd3, v);
            check("R2 R5 first result", v, VEC[i].r1);
            peek(4'd4, v);
            check("R2 R5 second result", v, VEC[i].r2);
            check("R6 R7 R8 carry bit31", {31'd0, ctl_reg[31]}, {31'd0, VEC[i].c1});
            check("R6 R7 R8 carry bit30", {31'd0, ctl_reg[30]}, {31'd0, VEC[i].c2});
            check("R8 low bits", {2'b00, ctl_reg[29:0]}, 32'h0);
        end

        // R3: padding nonzero
        load(4'd1, 32'd5);
        load(4'd2, 32'd3);
        issue(mk(2'd3, 2'b01, 4'd4, 4'd2, 4'd1, 4'd3));
        peek(4'd3, v);
        check("R3 first dest kept", v, 32'hFFFFFFF9);
        peek(4'd4, v);
        check("R3 second dest kept", v, 32'd7);
        check("R3 ctl kept", ctl_reg, 32'h0);

        // R4: both destinations zero
        issue(mk(2'd3, 2'b00, 4'd0, 4'd2, 4'd1, 4'd0));
        check("R4 ctl kept", ctl_reg, 32'h0);
        peek(4'd0, v);
        check("R4 entry0 zero", v, 32'h0);

        // R1: wrong minor, wrong major, low strobe
        issue(mk(2'd3, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3) ^ 32'h1);
        peek(4'd3, v);
        check("R1 wrong minor ignored", v, 32'hFFFFFFF9);
        check("R1 wrong minor ctl", ctl_reg, 32'h0);
        issue(mk(2'd3, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3) ^ (32'h1 << 26));
        peek(4'd4, v);
        check("R1 wrong major ignored", v, 32'd7);
        check("R1 wrong major ctl", ctl_reg, 32'h0);
        @(negedge clk);
        insn_word = mk(2'd3, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3);
        @(negedge clk);
        peek(4'd3, v);
        check("R1 strobe low ignored", v, 32'hFFFFFFF9);
        check("R1 strobe low ctl", ctl_reg, 32'h0);

        // R9: one destination zero
        issue(mk(2'd3, 2'b00, 4'd4, 4'd2, 4'd1, 4'd0));
        peek(4'd4, v);
        check("R9 second path written", v, 32'd2);
        check("R9 only bit30 set", ctl_reg, 32'h40000000);
        issue(mk(2'd2, 2'b00, 4'd0, 4'd2, 4'd1, 4'd3));
        peek(4'd3, v);
        check("R9 first path written", v, 32'd2);
        check("R9 bit30 kept", ctl_reg, 32'hC0000000);
        issue(mk(2'd0, 2'b00, 4'd4, 4'd2, 4'd1, 4'd0));
        peek(4'd4, v);
        check("R9 second path add", v, 32'd8);
        check("R9 bit31 kept", ctl_reg, 32'h80000000);

        // R10: destination aliases a source
        issue(mk(2'd1, 2'b00, 4'd4, 4'd2, 4'd1, 4'd1));
        peek(4'd1, v);
        check("R10 aliased dest", v, 32'd8);
        peek(4'd4, v);
        check("R10 other path used old source", v, 32'd2);
        check("R10 ctl", ctl_reg, 32'h40000000);

        // R13: both destinations equal
        issue(mk(2'd2, 2'b00, 4'd5, 4'd2, 4'd1, 4'd5));
        peek(4'd5, v);
        check("R13 second path wins", v, 32'd11);
        check("R13 ctl", ctl_reg, 32'h80000000);

        // R11: entry zero
        load(4'd0, 32'hDEADBEEF);
        peek(4'd0, v);
        check("R11 load to entry0 dropped", v, 32'h0);
        issue(mk(2'd2, 2'b00, 4'd7, 4'd2, 4'd0, 4'd6));
        peek(4'd6, v);
        check("R11 zero source sub", v, 32'hFFFFFFFD);
        peek(4'd7, v);
        check("R11 zero source add", v, 32'd3);
        check("R11 ctl", ctl_reg, 32'h0);

        // R12: reset in mid-run
        load(4'd1, 32'd5);
        issue(mk(2'd0, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3) | (32'd0));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        peek(4'd6, v);
        check("R12 entry cleared", v, 32'h0);
        check("R12 ctl cleared", ctl_reg, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule